// File: doc/BRIEF.md
# Masked Edge-Capture Interrupt Collector

The block watches a wide bus of internal event levels that are split into five categories: four channel groups and one common group. Each event is gated by its own mask bit. A 0-to-1 change of the gated condition latches a sticky monitor bit. The change can come from the event itself or from a mask bit being turned on while the event is already high. A latched bit stays set until software writes 1 to its position. Turning the mask off later does not release it.

A small register port reads the monitor, mask and selection registers, writes the masks, clears monitor bits and chooses what each interrupt output follows. Each output can follow one category or all of them. An output stays high while any monitor bit it follows is set. Several bits may be set at once, so software reads the monitor registers to find every source.

Top module: `irq_collector`

## Requirements
- R1: After reset every monitor bit and every mask bit is 0, each output selection reads 7 (all categories), and every interrupt output is 0.
- R2: When the gated condition `evt[i] & mask[i]` was 0 at one clock edge and is 1 at the next edge, monitor bit i reads 1 after that next edge.
- R3: If the gated condition stays 1 after its monitor bit has been cleared, the bit stays 0 until the condition is seen at 0 and then at 1 again.
- R4: After a mask write sets bit i while `evt[i]` is already 1, monitor bit i reads 1 one clock after the write has taken effect.
- R5: Writing 0 to a mask bit leaves a monitor bit that is already set at 1.
- R6: Writing `wr_data` to monitor address c (0 to 4) clears monitor bit `c*8+k` for each k where `wr_data[k]` is 1. Bits written with 0 keep their value. If a clear meets a new rising edge of the same bit in the same cycle, the bit ends up set.
- R7: An event whose mask bit is 0 never sets its monitor bit, however it toggles.
- R8: The selection register of output p is at address 10+p and uses bits [2:0]. A value of 0 to 4 makes the output follow category 0 to 4. Values 5 to 7 make it follow all categories. Category c holds events `c*8` to `c*8+7`, and category 4 is the common group.
- R9: An interrupt output is 1 exactly when at least one monitor bit it follows is 1, and it stays 1 while several bits are set, until the last of them is cleared.
- R10: Reading `rd_data` is combinational from `rd_addr`. Addresses 0 to 4 return the monitor byte of category c. Addresses 5 to 9 return the mask byte of category c-5. Addresses 10 and 11 return the selections zero-extended. Every other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 40 | Event levels; bit c*8+k belongs to category c |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 2 | Interrupt outputs, one per selection register |

## Verification
On every cycle, the assertions check four things: a monitor bit only rises if its gated condition was high one edge earlier, a bit only falls after a write to a monitor address, a mask or selection write never drops a latched bit, and an output is never high while all monitor bits are 0. Only the bench's scenarios can show the edge-only behaviour. These include an event held high across a clear, a mask being enabled under a live event, and the set-over-clear priority. The scenarios also cover category routing for each selection value and the full read map, all checked against a per-cycle reference model.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NUM_CAT    = 5,
  parameter int EV_PER_CAT = 8,
  parameter int NUM_PINS   = 2,
  parameter int ADDR_W     = 4,
  parameter int SEL_W      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CAT*EV_PER_CAT-1:0]  evt,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [EV_PER_CAT-1:0]          wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [EV_PER_CAT-1:0]          rd_data,
  output logic [NUM_PINS-1:0]            irq
);
  localparam int NUM_EV    = NUM_CAT * EV_PER_CAT;
  localparam int MASK_BASE = NUM_CAT;
  localparam int SEL_BASE  = 2 * NUM_CAT;

  logic [NUM_EV-1:0]         mon, mask, prev, cond, clr;
  logic [NUM_CAT-1:0]        cat_any;
  logic [NUM_PINS*SEL_W-1:0] sel;

  assign cond = evt & mask;

  genvar c, p;
  generate
    for (c = 0; c < NUM_CAT; c++) begin : g_cat
      assign clr[c*EV_PER_CAT +: EV_PER_CAT] =
        (wr_en && wr_addr == ADDR_W'(c)) ? wr_data : '0;
      assign cat_any[c] = |mon[c*EV_PER_CAT +: EV_PER_CAT];
    end
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [SEL_W-1:0] s;
      assign s = sel[p*SEL_W +: SEL_W];
      assign irq[p] = (s >= SEL_W'(NUM_CAT)) ? |mon : cat_any[s];
      a_r9_pin_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
        irq[p] |-> (mon != '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon  <= '0;
      prev <= '0;
      mask <= '0;
      sel  <= '1;
    end else begin
      mon  <= (mon & ~clr) | (cond & ~prev);
      prev <= cond;
      for (int i = 0; i < NUM_CAT; i++)
        if (wr_en && wr_addr == ADDR_W'(MASK_BASE + i))
          mask[i*EV_PER_CAT +: EV_PER_CAT] <= wr_data;
      for (int j = 0; j < NUM_PINS; j++)
        if (wr_en && wr_addr == ADDR_W'(SEL_BASE + j))
          sel[j*SEL_W +: SEL_W] <= wr_data[SEL_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CAT; i++) begin
      if (rd_addr == ADDR_W'(i))             rd_data = mon[i*EV_PER_CAT +: EV_PER_CAT];
      if (rd_addr == ADDR_W'(MASK_BASE + i)) rd_data = mask[i*EV_PER_CAT +: EV_PER_CAT];
    end
    for (int j = 0; j < NUM_PINS; j++)
      if (rd_addr == ADDR_W'(SEL_BASE + j)) rd_data[SEL_W-1:0] = sel[j*SEL_W +: SEL_W];
  end

  a_r2_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (mon & ~$past(mon) & ~$past(evt & mask)) == '0);

  a_r6_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mon) & ~mon) != '0) |-> $past(wr_en && wr_addr < ADDR_W'(NUM_CAT)));

  a_r5_mask_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr >= ADDR_W'(NUM_CAT)) |-> (($past(mon) & ~mon) == '0));
endmodule

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5, EP = 8, NE = 40, NP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [NP-1:0] irq;

  irq_collector u_irq_collector (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NE-1:0] m_mon, m_mask, m_last;
  int m_sel [NP];
  int vectors = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  always @(posedge clk) begin
    logic [NE-1:0] gated, wipe;
    if (!rst_n) begin
      m_mon = '0; m_mask = '0; m_last = '0;
      foreach (m_sel[k]) m_sel[k] = 7;
    end else begin
      gated = evt & m_mask;
      wipe = '0;
      if (wr_en && wr_addr < NC) wipe = NE'(wr_data) << (EP * int'(wr_addr));
      for (int b = 0; b < NE; b++) begin
        if (gated[b] && !m_last[b]) m_mon[b] = 1'b1;
        else if (wipe[b])          m_mon[b] = 1'b0;
      end
      m_last = gated;
      if (wr_en && wr_addr >= NC && wr_addr < 2*NC)
        m_mask[(int'(wr_addr)-NC)*EP +: EP] = wr_data;
      if (wr_en && wr_addr >= 2*NC && wr_addr < 2*NC+NP)
        m_sel[int'(wr_addr)-2*NC] = int'(wr_data[2:0]);
    end
  end

  function automatic logic [7:0] exp_rd(input int a);
    if (a < NC) return m_mon[a*EP +: EP];
    if (a < 2*NC) return m_mask[(a-NC)*EP +: EP];
    if (a < 2*NC+NP) return 8'(m_sel[a-2*NC]);
    return 8'h00;
  endfunction

  function automatic logic [NP-1:0] exp_irq();
    logic [NP-1:0] r;
    for (int k = 0; k < NP; k++)
      r[k] = (m_sel[k] >= NC) ? |m_mon : |m_mon[m_sel[k]*EP +: EP];
    return r;
  endfunction

  task automatic compare();
    vectors++;
    if (irq !== exp_irq()) begin
      errors++;
      $display("FAIL %s irq: got %b expected %b", tag, irq, exp_irq());
    end
    if (rd_data !== exp_rd(int'(rd_addr))) begin
      errors++;
      $display("FAIL %s rd[%0d]: got %h expected %h", tag, rd_addr, rd_data, exp_rd(int'(rd_addr)));
    end
  endtask

  task automatic expect_bit(input string t, input int b, input logic v);
    logic [3:0] keep;
    keep = rd_addr;
    rd_addr = 4'(b / EP);
    #1;
    vectors++;
    if (rd_data[b % EP] !== v) begin
      errors++;
      $display("FAIL %s mon bit %0d: got %b expected %b", t, b, rd_data[b % EP], v);
    end
    rd_addr = keep;
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      compare();
      rd_addr = rd_addr + 4'd1;
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tag = "R1"; step(3);
    rst_n = 1'b1; step(16);
    vectors++;
    if (irq !== 2'b00) begin errors++; $display("FAIL R1 irq: got %b expected 00", irq); end

    tag = "R7"; evt = '1; step(3); evt = '0; step(2); evt = '1; step(3);
    expect_bit("R7", 20, 1'b0);

    tag = "R4"; wr(6, 8'h01); step(1);
    expect_bit("R4", 8, 1'b1);
    step(2);

    tag = "R3"; wr(1, 8'h01); step(3);
    expect_bit("R3", 8, 1'b0);
    evt[8] = 1'b0; step(2);
    expect_bit("R3", 8, 1'b0);
    evt[8] = 1'b1; step(1);
    expect_bit("R3", 8, 1'b1);

    tag = "R6"; wr(1, 8'h00); expect_bit("R6", 8, 1'b1);
    evt = '0; wr(5, 8'hFF); step(1);
    evt[3] = 1'b1; evt[5] = 1'b1; step(1);
    expect_bit("R6", 3, 1'b1);
    evt[3] = 1'b0; step(1);
    evt[3] = 1'b1; wr(0, 8'h08);
    expect_bit("R6", 3, 1'b1);
    wr(0, 8'h20); expect_bit("R6", 5, 1'b0);

    tag = "R5"; wr(6, 8'h00); expect_bit("R5", 8, 1'b1); step(2);

    tag = "R8"; wr(0, 8'hFF); wr(1, 8'hFF); step(1);
    wr(10, 8'h01); wr(11, 8'h04); step(2);
    wr(9, 8'h81); evt[32] = 1'b1; evt[39] = 1'b1; step(2);
    wr(10, 8'h05); step(1);
    wr(10, 8'h02); step(1);
    wr(6, 8'h10); evt[12] = 1'b1; step(2);
    wr(10, 8'h01); step(1);

    tag = "R9"; wr(4, 8'h01); step(1); wr(4, 8'h80); step(1);
    wr(1, 8'h10); step(2);

    tag = "R10"; wr(7, 8'hA5); wr(8, 8'h3C);
    for (int a = 0; a < 16; a++) begin rd_addr = 4'(a); #1; step(1); end

    tag = "R2"; evt = '0; wr(7, 8'h0F); step(2);
    evt[17] = 1'b1; step(1); expect_bit("R2", 17, 1'b1);
    evt[18] = 1'b1; evt[20] = 1'b1; step(2);
    expect_bit("R2", 20, 1'b0);

    tag = "R1"; rst_n = 1'b0; step(2); rst_n = 1'b1; step(12);
    summary();
  end
endmodule